// File: doc/BRIEF.md
# Transport Stream Packet Start Marker

This block sits in a byte-wide streaming path that carries MPEG-2 transport stream packets. It finds the packet grid and forwards bytes downstream with two sideband strobes. One strobe marks the first byte of each packet. The other marks the last byte, which is the 188th byte transferred. A downstream device that needs to know where a packet boundary falls can then frame the stream without inspecting the data.

Both sides of the block use a valid/ready handshake. Until the block has seen the sync value 0x47 at two positions exactly 188 accepted bytes apart, it consumes and drops every byte. The byte that completes this check is the first byte forwarded, and it carries the start strobe. While locked, the block forwards every byte unchanged and keeps track of the byte position inside the current packet. If a packet opens with any value other than 0x47, the block drops that byte, raises a one-cycle error pulse and starts searching again.

Top module: `ts_sop_marker`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `locked` = 0 and `sync_err` = 0. Because the block is then unlocked, `out_valid` stays 0 after reset.
- R2: While unlocked, the block accepts every byte (`in_ready` = 1 whatever `out_ready` is) and forwards none (`out_valid` = 0). The one exception is the byte that completes lock (R3).
- R3: Lock needs two accepted bytes of value 0x47 exactly 188 accepted bytes apart. The second of them is forwarded with `out_sop` = 1, and `locked` reads 1 in the cycle after it is accepted.
- R4: If a 0x47 byte is followed 188 accepted bytes later by a byte that is not 0x47, the block does not lock, forwards nothing and raises no `sync_err`.
- R5: While locked, every byte is forwarded with `out_data` equal to `in_data`. `out_sop` is 1 only on packet position 0, and `out_last` is 1 only on position 187. A 0x47 value inside the payload has no effect on either strobe.
- R6: While locked, a byte at position 0 whose value is not 0x47 is dropped (`out_valid` = 0). In the cycle after it is accepted, `sync_err` is 1 for exactly one cycle and `locked` is 0.
- R7: The byte position advances only on an accepted transfer (`in_valid` and `in_ready` both 1). While locked and forwarding, `in_ready` equals `out_ready`. While `out_ready` is 0, the offered byte, `out_sop` and `out_last` hold.
- R8: A synchronous reset in the middle of a locked packet returns the block to the unlocked search state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | Incoming byte is offered |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| out_data | output | 8 | Forwarded stream byte |
| out_valid | output | 1 | Forwarded byte is offered downstream |
| out_ready | input | 1 | Downstream takes the forwarded byte |
| out_sop | output | 1 | Forwarded byte is packet position 0 |
| out_last | output | 1 | Forwarded byte is packet position 187 |
| sync_err | output | 1 | One-cycle pulse: lock lost on a bad sync byte |
| locked | output | 1 | Packet grid acquired |

## Verification
The hold properties assume that the upstream source keeps `in_data` and `in_valid` steady while a forwarded byte waits on `out_ready`. This is the usual valid/ready rule. The stimulus changes its inputs only after a transfer completes or while `in_valid` is low. The stimulus also keeps 0x47 out of the payload in packets that are sent while the block is unlocked, so that each acquisition starts at a known byte. Payload 0x47 values are placed only in packets that arrive while the block is locked, and these check that the strobes ignore them.

// File: rtl/ts_sop_pkg.sv
package ts_sop_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned TS_PKT_LEN = 188;
    localparam logic [BYTE_W-1:0] TS_SYNC = 8'h47;

    typedef logic [BYTE_W-1:0] stream_byte_t;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

    typedef struct packed {
        stream_byte_t data;
        logic         sop;
        logic         last;
    } beat_t;

    function automatic logic match_sync(input stream_byte_t b, input stream_byte_t s);
        return b == s;
    endfunction

endpackage

// File: rtl/ts_pos_counter.sv
module ts_pos_counter #(
    parameter int unsigned PKT_LEN = 188,
    localparam int unsigned POS_W  = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load_one,
    input  logic             advance,
    output logic [POS_W-1:0] pos,
    output logic             at_first,
    output logic             at_last
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
        end else if (load_one) begin
            pos <= POS_W'(1);
        end else if (advance) begin
            pos <= (pos == LAST_POS) ? '0 : pos + POS_W'(1);
        end
    end

    assign at_first = (pos == '0);
    assign at_last  = (pos == LAST_POS);

endmodule

// File: rtl/ts_lock_fsm.sv
module ts_lock_fsm
    import ts_sop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        is_sync,
    input  logic        at_first,
    output logic        pass,
    output logic        clear,
    output logic        load_one,
    output logic        advance,
    output logic        err_pulse,
    output logic        is_locked
);

    lock_state_e st, st_nxt;
    logic        err_d;

    always_comb begin
        st_nxt   = st;
        clear    = 1'b0;
        load_one = 1'b0;
        advance  = 1'b0;
        err_d    = 1'b0;
        case (st)
            ST_SEARCH: begin
                if (accept && is_sync) begin
                    st_nxt   = ST_VERIFY;
                    load_one = 1'b1;
                end
            end
            ST_VERIFY: begin
                if (accept) begin
                    if (at_first && !is_sync) begin
                        st_nxt = ST_SEARCH;
                        clear  = 1'b1;
                    end else begin
                        advance = 1'b1;
                        if (at_first) st_nxt = ST_LOCKED;
                    end
                end
            end
            ST_LOCKED: begin
                if (accept) begin
                    if (at_first && !is_sync) begin
                        st_nxt = ST_SEARCH;
                        clear  = 1'b1;
                        err_d  = 1'b1;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            default: begin
                st_nxt = ST_SEARCH;
                clear  = 1'b1;
            end
        endcase
    end

    // Forward while locked (except a bad sync byte) or on the byte that confirms lock.
    assign pass = ((st == ST_LOCKED) && (!at_first || is_sync)) ||
                  ((st == ST_VERIFY) && at_first && is_sync);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_SEARCH;
            err_pulse <= 1'b0;
        end else begin
            st        <= st_nxt;
            err_pulse <= err_d;
        end
    end

    assign is_locked = (st == ST_LOCKED);

endmodule

// File: rtl/ts_sop_marker.sv
module ts_sop_marker
    import ts_sop_pkg::*;
#(
    parameter int unsigned  PKT_LEN   = TS_PKT_LEN,
    parameter stream_byte_t SYNC_BYTE = TS_SYNC,
    localparam int unsigned POS_W     = $clog2(PKT_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_last,
    output logic              sync_err,
    output logic              locked
);

    logic             pass, accept, is_sync;
    logic             clear, load_one, advance;
    logic             at_first, at_last;
    logic [POS_W-1:0] pos;
    beat_t            beat;

    assign is_sync  = match_sync(in_data, SYNC_BYTE);
    // Dropped bytes are always consumed; forwarded bytes follow downstream readiness.
    assign in_ready = pass ? out_ready : 1'b1;
    assign accept   = in_valid && in_ready;

    ts_lock_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .is_sync   (is_sync),
        .at_first  (at_first),
        .pass      (pass),
        .clear     (clear),
        .load_one  (load_one),
        .advance   (advance),
        .err_pulse (sync_err),
        .is_locked (locked)
    );

    ts_pos_counter #(.PKT_LEN(PKT_LEN)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .load_one (load_one),
        .advance  (advance),
        .pos      (pos),
        .at_first (at_first),
        .at_last  (at_last)
    );

    always_comb begin
        beat.data = in_data;
        beat.sop  = at_first;
        beat.last = at_last;
    end

    assign out_valid = in_valid && pass;
    assign out_data  = beat.data;
    assign out_sop   = out_valid && beat.sop;
    assign out_last  = out_valid && beat.last;

endmodule

// File: rtl/ts_sop_marker_chk.sv
module ts_sop_marker_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_sop,
    input logic       out_last,
    input logic       sync_err,
    input logic       locked
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!locked && !sync_err));

    // R3
    lock_on_sop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(out_sop && out_ready));

    // R5
    sop_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_sop || out_last) |-> out_valid);

    // R5
    sop_last_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_sop && out_last));

    // R6
    err_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> !locked);

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

    // R7
    ready_follows_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_ready == out_ready));

    // R7
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_last)));

    // R2
    unlocked_consumes_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && in_valid && !out_valid) |-> in_ready);

endmodule

bind ts_sop_marker ts_sop_marker_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_last  (out_last),
    .sync_err  (sync_err),
    .locked    (locked)
);

// File: tb/test_ts_sop_marker.sv
module test_ts_sop_marker;

    localparam int CLK_PERIOD = 10;
    localparam int PLEN       = 188;

    typedef struct packed {
        logic [7:0] head;
        logic       pass;
        logic       err;
        logic       lock_after;
        logic       pay_sync;
    } pkt_vec_t;

    // Packet-level vectors: head byte, forwarded?, sync_err on head?, locked after, 0x47 in payload
    localparam pkt_vec_t VEC [7] = '{
        '{8'h47, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 first sync seen, still searching
        '{8'h47, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 second boundary locks
        '{8'h47, 1'b1, 1'b0, 1'b1, 1'b1},  // R5 payload 0x47 ignored
        '{8'h12, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 bad head drops lock
        '{8'h47, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 re-search
        '{8'h47, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 relock
        '{8'h47, 1'b1, 1'b0, 1'b1, 1'b1}   // R5
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       out_sop;
    logic       out_last;
    logic       sync_err;
    logic       locked;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_sop_marker i_ts_sop_marker (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_sop   (out_sop),
        .out_last  (out_last),
        .sync_err  (sync_err),
        .locked    (locked)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] payload(input int i, input logic sy);
        return (sy && i == 100) ? 8'h47 : 8'(i % 64);
    endfunction

    // Offer one byte with out_ready high; check combinational outputs, then the registered error.
    task automatic send_byte(input logic [7:0] d, input logic e_pass, input logic e_sop,
                             input logic e_last, input logic e_err, input string req);
        in_data  = d;
        in_valid = 1'b1;
        out_ready = 1'b1;
        #2;
        chk(out_valid == e_pass, req, "out_valid", int'(out_valid), int'(e_pass));
        chk(out_sop == e_sop, req, "out_sop", int'(out_sop), int'(e_sop));
        chk(out_last == e_last, req, "out_last", int'(out_last), int'(e_last));
        chk(in_ready == 1'b1, req, "in_ready", int'(in_ready), 1);
        if (e_pass) chk(out_data == d, req, "out_data", int'(out_data), int'(d));
        @(posedge clk); #1;
        chk(sync_err == e_err, req, "sync_err", int'(sync_err), int'(e_err));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(posedge clk);
        #1;
        chk(locked == 1'b0, "R1", "locked", int'(locked), 0);
        chk(sync_err == 1'b0, "R1", "sync_err", int'(sync_err), 0);
        rst = 1'b0;
        // R2 unlocked: consumed even when downstream stalls
        in_data = 8'h55; in_valid = 1'b1; out_ready = 1'b0;
        #2;
        chk(out_valid == 1'b0, "R2", "out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R2", "in_ready", int'(in_ready), 1);
        @(posedge clk); #1;
        in_valid = 1'b0;

        // Packet vector table
        foreach (VEC[k]) begin
            for (int i = 0; i < PLEN; i++) begin
                send_byte(i == 0 ? VEC[k].head : payload(i, VEC[k].pay_sync),
                          VEC[k].pass, VEC[k].pass && i == 0,
                          VEC[k].pass && i == PLEN - 1,
                          VEC[k].err && i == 0, "R5");
            end
            chk(locked == VEC[k].lock_after, "R3", "locked", int'(locked), int'(VEC[k].lock_after));
        end

        // R7 backpressure on the head byte of a locked packet
        in_data = 8'h47; in_valid = 1'b1; out_ready = 1'b0;
        for (int s = 0; s < 3; s++) begin
            #2;
            chk(in_ready == 1'b0, "R7", "in_ready", int'(in_ready), 0);
            chk(out_sop == 1'b1, "R7", "out_sop held", int'(out_sop), 1);
            chk(out_valid == 1'b1, "R7", "out_valid held", int'(out_valid), 1);
            @(posedge clk); #1;
        end
        out_ready = 1'b1;
        #2;
        chk(in_ready == 1'b1, "R7", "in_ready", int'(in_ready), 1);
        chk(out_sop == 1'b1, "R7", "out_sop", int'(out_sop), 1);
        @(posedge clk); #1;
        // R7 idle gap does not advance position
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        for (int i = 1; i < PLEN; i++)
            send_byte(payload(i, 1'b0), 1'b1, 1'b0, i == PLEN - 1, 1'b0, "R7");
        chk(locked == 1'b1, "R7", "locked", int'(locked), 1);

        // R8 reset mid-packet
        for (int i = 0; i < 10; i++)
            send_byte(i == 0 ? 8'h47 : payload(i, 1'b0), 1'b1, i == 0, 1'b0, 1'b0, "R8");
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        chk(locked == 1'b0, "R8", "locked", int'(locked), 0);
        chk(sync_err == 1'b0, "R8", "sync_err", int'(sync_err), 0);

        // R4 lone 0x47 without a matching boundary
        for (int i = 0; i < PLEN; i++)
            send_byte(i == 0 ? 8'h47 : payload(i, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        send_byte(8'h13, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        chk(locked == 1'b0, "R4", "locked", int'(locked), 0);

        // R3 acquisition afterwards
        for (int i = 0; i < PLEN; i++)
            send_byte(i == 0 ? 8'h47 : payload(i, 1'b0), 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        send_byte(8'h47, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
        chk(locked == 1'b1, "R3", "locked", int'(locked), 1);
        in_valid = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule